// File: doc/BRIEF.md
# I2C Transmit-Completion Flag and Transfer-Trigger Unit

This block sits beside an I2C byte shifter and decides which status flags to raise each time a transmitted byte completes. It keeps three sticky flags: a data-register-empty flag, a general interrupt flag and a transfer-request flag. The transfer-request flag starts an external DMA-style engine. The acknowledge bit returned by the receiver selects which of the three flags are set. An acknowledge-check enable input decides whether that bit is used at all.

The unit also holds the DMA engine's remaining byte count. Software loads the count with a start strobe. Each DMA acknowledge decrements it. On the final decrement, from 1 to 0, the burst is over: the unit clears all three flags and, in master mode, sends a one-cycle request to the shifter to issue a stop condition. The CPU interrupt is masked while a transfer request is pending, so bytes handled by the engine raise no interrupt. A NACK seen while acknowledge checking is enabled withholds the trigger and so leaves the CPU to handle the byte.

Top module: `iic_txc_flag_ctrl`

## Requirements
- R1: After reset, all three flags, the interrupt output, the stop request and the remaining count are 0.
- R2: With acknowledge checking disabled (`ack_chk_en_i`=0), a `byte_done_i` pulse sets the empty, interrupt and request flags in the next cycle, whatever the value of `ack_bit_i`.
- R3: With acknowledge checking enabled and `ack_bit_i`=0 (ACK), a `byte_done_i` pulse sets all three flags in the next cycle.
- R4: With acknowledge checking enabled and `ack_bit_i`=1 (NACK), a `byte_done_i` pulse sets only the interrupt flag. It does not set the empty flag or the request flag.
- R5: `irq_o` is high exactly when the interrupt flag is set, `irq_en_i` is 1 and the request flag is clear. A pending DMA trigger therefore never raises a CPU interrupt.
- R6: `cnt_load_i` loads `cnt_value_i` into the remaining count. Otherwise each `dma_ack_i` decrements a nonzero count by 1. A load in the same cycle as an acknowledge wins. An acknowledge at count 0 leaves the count at 0.
- R7: A `dma_ack_i` that takes the count from 1 to 0 clears all three flags in the next cycle. A flag that a `byte_done_i` sets in the same cycle is still set.
- R8: `cpu_clr_i` is a write-zero mask: bit 0 clears the empty flag, bit 1 the interrupt flag and bit 2 the request flag. A flag that `byte_done_i` sets in the same cycle stays set.
- R9: In master mode (`master_i`=1), `stop_req_o` pulses high for exactly one cycle, in the cycle after the count goes from 1 to 0. It never pulses in slave mode, and never when the count was loaded as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_done_i | input | 1 | One-cycle pulse when a transmitted byte and its acknowledge slot complete |
| ack_bit_i | input | 1 | Sampled acknowledge bit (0 = ACK, 1 = NACK) |
| ack_chk_en_i | input | 1 | Acknowledge-check enable |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| irq_en_i | input | 1 | Interrupt enable |
| cpu_clr_i | input | 3 | Write-zero clear mask {request, interrupt, empty} |
| cnt_load_i | input | 1 | Start strobe that loads the byte count |
| cnt_value_i | input | CNT_W | Byte count to load |
| dma_ack_i | input | 1 | DMA engine has moved one byte |
| data_empty_o | output | 1 | Data-register-empty flag |
| intr_flag_o | output | 1 | General interrupt flag |
| xfer_req_o | output | 1 | Transfer-request flag (DMA trigger) |
| irq_o | output | 1 | CPU interrupt request |
| stop_req_o | output | 1 | One-cycle automatic stop request |
| remain_o | output | CNT_W | Remaining DMA byte count |

## Verification
The bound assertions check several properties on every cycle. Full flag setting follows an ACK or unchecked byte, and a NACK never sets the request flag. The interrupt stays low while a request is pending. The count steps down by one per acknowledge, the flags clear when the count runs out, and the stop pulse is one cycle long and only appears in master mode. Some behaviour only the bench scenarios show: the per-bit effect of every clear mask, set-wins collisions with both clear paths, load-over-acknowledge priority, and that a zero load never produces a stop. The bench also sweeps the exact stop timing across counts and modes.

// File: rtl/iic_txc_pkg.sv
package iic_txc_pkg;
  localparam int NUM_FLAGS = 3;
  localparam int FLG_EMPTY = 0;
  localparam int FLG_INTR  = 1;
  localparam int FLG_REQ   = 2;
  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/iic_txc_rst_sync.sv
module iic_txc_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/iic_txc_flag_unit.sv
module iic_txc_flag_unit
  import iic_txc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  logic      byte_done_i,
  input  logic      ack_bit_i,
  input  logic      ack_chk_en_i,
  input  flag_vec_t clr_mask_i,
  input  logic      burst_end_i,
  output flag_vec_t flags_o
);
  logic      full_set;
  flag_vec_t set_vec;
  flag_vec_t clr_vec;
  flag_vec_t flags_d;
  flag_vec_t flags_q;

  // Set vector: a NACK under checking raises only the interrupt flag
  always_comb begin
    full_set           = !ack_chk_en_i || !ack_bit_i;
    set_vec            = '0;
    set_vec[FLG_INTR]  = byte_done_i;
    set_vec[FLG_EMPTY] = byte_done_i && full_set;
    set_vec[FLG_REQ]   = byte_done_i && full_set;
    clr_vec            = clr_mask_i | {NUM_FLAGS{burst_end_i}};
  end

  // Per-bit next state: set wins over any clear
  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    always_comb begin
      flags_d[gi] = set_vec[gi] | (flags_q[gi] & ~clr_vec[gi]);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) flags_q[gi] <= 1'b0;
      else          flags_q[gi] <= flags_d[gi];
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/iic_txc_byte_cnt.sv
module iic_txc_byte_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dma_ack_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             exhaust_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             dec_ok;

  always_comb begin
    dec_ok    = dma_ack_i && (cnt_q != '0) && !load_i;
    exhaust_o = dec_ok && (cnt_q == CNT_ONE);
    cnt_en    = load_i || dec_ok;
    cnt_d     = load_i ? load_val_i : (cnt_q - CNT_ONE);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign remain_o = cnt_q;
endmodule

// File: rtl/iic_txc_stop_gen.sv
module iic_txc_stop_gen (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic exhaust_i,
  input  logic master_i,
  output logic stop_req_o
);
  logic stop_d;
  logic stop_q;

  always_comb begin
    stop_d = exhaust_i && master_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stop_q <= 1'b0;
    else          stop_q <= stop_d;
  end

  assign stop_req_o = stop_q;
endmodule

// File: rtl/iic_txc_flag_ctrl.sv
module iic_txc_flag_ctrl
  import iic_txc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             byte_done_i,
  input  logic             ack_bit_i,
  input  logic             ack_chk_en_i,
  input  logic             master_i,
  input  logic             irq_en_i,
  input  logic [2:0]       cpu_clr_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_value_i,
  input  logic             dma_ack_i,
  output logic             data_empty_o,
  output logic             intr_flag_o,
  output logic             xfer_req_o,
  output logic             irq_o,
  output logic             stop_req_o,
  output logic [CNT_W-1:0] remain_o
);
  logic      rst_sync_n;
  logic      exhaust;
  flag_vec_t flags;

  iic_txc_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  iic_txc_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .load_i     (cnt_load_i),
    .load_val_i (cnt_value_i),
    .dma_ack_i  (dma_ack_i),
    .remain_o   (remain_o),
    .exhaust_o  (exhaust)
  );

  iic_txc_flag_unit u_flags (
    .clk_i        (clk_i),
    .rst_n_i      (rst_sync_n),
    .byte_done_i  (byte_done_i),
    .ack_bit_i    (ack_bit_i),
    .ack_chk_en_i (ack_chk_en_i),
    .clr_mask_i   (cpu_clr_i),
    .burst_end_i  (exhaust),
    .flags_o      (flags)
  );

  iic_txc_stop_gen u_stop (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .exhaust_i  (exhaust),
    .master_i   (master_i),
    .stop_req_o (stop_req_o)
  );

  assign data_empty_o = flags[FLG_EMPTY];
  assign intr_flag_o  = flags[FLG_INTR];
  assign xfer_req_o   = flags[FLG_REQ];
  assign irq_o        = flags[FLG_INTR] & irq_en_i & ~flags[FLG_REQ];
endmodule

// File: rtl/iic_txc_flag_ctrl_chk.sv
module iic_txc_flag_ctrl_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ok,
  input logic             byte_done_i,
  input logic             ack_bit_i,
  input logic             ack_chk_en_i,
  input logic             master_i,
  input logic [2:0]       cpu_clr_i,
  input logic             cnt_load_i,
  input logic             dma_ack_i,
  input logic             data_empty_o,
  input logic             intr_flag_o,
  input logic             xfer_req_o,
  input logic             irq_o,
  input logic             stop_req_o,
  input logic [CNT_W-1:0] remain_o
);
  AST_FULL_SET: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (byte_done_i && (!ack_chk_en_i || !ack_bit_i)) |=> (data_empty_o && intr_flag_o && xfer_req_o)); // R2

  AST_NACK_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (byte_done_i && ack_chk_en_i && ack_bit_i && !xfer_req_o) |=> (intr_flag_o && !xfer_req_o)); // R4

  AST_NO_IRQ_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ok)
    xfer_req_o |-> !irq_o); // R5

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (dma_ack_i && !cnt_load_i && remain_o != '0) |=> (remain_o == $past(remain_o) - CNT_W'(1))); // R6

  AST_BURST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (dma_ack_i && !cnt_load_i && remain_o == CNT_W'(1) && !byte_done_i)
      |=> (!data_empty_o && !intr_flag_o && !xfer_req_o)); // R7

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ok)
    stop_req_o |=> !stop_req_o); // R9

  AST_STOP_MASTER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ok)
    $rose(stop_req_o) |-> ($past(master_i) && remain_o == '0)); // R9

  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ok)
    (cpu_clr_i == 3'b111 && !byte_done_i) |=> (!data_empty_o && !intr_flag_o && !xfer_req_o)); // R8
endmodule

bind iic_txc_flag_ctrl iic_txc_flag_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ok       (rst_sync_n),
  .byte_done_i  (byte_done_i),
  .ack_bit_i    (ack_bit_i),
  .ack_chk_en_i (ack_chk_en_i),
  .master_i     (master_i),
  .cpu_clr_i    (cpu_clr_i),
  .cnt_load_i   (cnt_load_i),
  .dma_ack_i    (dma_ack_i),
  .data_empty_o (data_empty_o),
  .intr_flag_o  (intr_flag_o),
  .xfer_req_o   (xfer_req_o),
  .irq_o        (irq_o),
  .stop_req_o   (stop_req_o),
  .remain_o     (remain_o)
);

// File: tb/iic_txc_flag_ctrl_tb.sv
module iic_txc_flag_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             byte_done, ack_bit, ack_chk_en, master, irq_en;
  logic [2:0]       cpu_clr;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_value;
  logic             dma_ack;
  logic             data_empty, intr_flag, xfer_req, irq, stop_req;
  logic [CNT_W-1:0] remain;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iic_txc_flag_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .byte_done_i(byte_done), .ack_bit_i(ack_bit),
    .ack_chk_en_i(ack_chk_en), .master_i(master), .irq_en_i(irq_en),
    .cpu_clr_i(cpu_clr), .cnt_load_i(cnt_load), .cnt_value_i(cnt_value),
    .dma_ack_i(dma_ack), .data_empty_o(data_empty), .intr_flag_o(intr_flag),
    .xfer_req_o(xfer_req), .irq_o(irq), .stop_req_o(stop_req), .remain_o(remain)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: inputs set at a falling edge are taken at the rising edge,
  // pulses drop at the next falling edge where outputs are sampled.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    byte_done = 0; dma_ack = 0; cnt_load = 0; cpu_clr = 3'b000;
  endtask

  function automatic int flags3();
    return {xfer_req, intr_flag, data_empty};
  endfunction

  task automatic clear_all();
    cpu_clr = 3'b111; tick();
  endtask

  task automatic set_full();
    ack_chk_en = 0; byte_done = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; byte_done = 0; ack_bit = 0; ack_chk_en = 0; master = 0; irq_en = 0;
    cpu_clr = 0; cnt_load = 0; cnt_value = 0; dma_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 flags", flags3(), 0);
    chk("R1 irq", irq, 0);
    chk("R1 stop", stop_req, 0);
    chk("R1 remain", remain, 0);

    // R2/R3/R4/R5: sweep acknowledge config, ack value, irq enable
    for (int e = 0; e < 2; e++)
      for (int a = 0; a < 2; a++)
        for (int ie = 0; ie < 2; ie++) begin
          int full;
          clear_all();
          ack_chk_en = e[0]; ack_bit = a[0]; irq_en = ie[0]; byte_done = 1;
          tick();
          full = (e == 0 || a == 0) ? 1 : 0;
          chk(e == 0 ? "R2 flags" : (a == 0 ? "R3 flags" : "R4 flags"),
              flags3(), full * 4 + 2 + full);
          chk("R5 irq", irq, (ie == 1 && full == 0) ? 1 : 0);
        end
    irq_en = 1;

    // R8: every clear mask applied to a full flag set
    for (int m = 0; m < 8; m++) begin
      clear_all();
      set_full();
      cpu_clr = m[2:0];
      tick();
      chk("R8 mask", flags3(), 7 & ~m);
      chk("R5 irq after mask", irq, ((~m & 2) != 0 && (~m & 4) == 0) ? 1 : 0);
    end
    // R8: set wins over a clear in the same cycle
    clear_all();
    ack_chk_en = 0; byte_done = 1; cpu_clr = 3'b111;
    tick();
    chk("R8 set wins", flags3(), 7);
    clear_all();
    ack_chk_en = 1; ack_bit = 1; byte_done = 1; cpu_clr = 3'b111;
    tick();
    chk("R8 nack set wins", flags3(), 2);

    // R6/R7/R9: count sweep across both modes
    for (int ms = 0; ms < 2; ms++)
      for (int n = 0; n < 5; n++) begin
        master = ms[0];
        clear_all();
        set_full();
        cnt_value = CNT_W'(n); cnt_load = 1;
        tick();
        chk("R6 load", remain, n);
        chk("R9 no stop on load", stop_req, 0);
        for (int k = 1; k <= n + 1; k++) begin
          dma_ack = 1;
          tick();
          chk("R6 remain", remain, (n >= k) ? n - k : 0);
          chk("R9 stop", stop_req, (ms == 1 && n > 0 && k == n) ? 1 : 0);
          if (n > 0 && k == n) chk("R7 burst clear", flags3(), 0);
        end
        if (n == 0) chk("R7 zero load keeps flags", flags3(), 7);
      end

    // R6: load wins over acknowledge
    cnt_value = 8'd5; cnt_load = 1; dma_ack = 1;
    tick();
    chk("R6 load priority", remain, 5);

    // R7: exhaust with a NACK byte in the same cycle
    master = 1;
    clear_all();
    set_full();
    cnt_value = 8'd1; cnt_load = 1; tick();
    ack_chk_en = 1; ack_bit = 1; byte_done = 1; dma_ack = 1;
    tick();
    chk("R7 nack collision", flags3(), 2);
    chk("R9 stop collision", stop_req, 1);
    chk("R5 irq after nack burst", irq, 1);
    tick();
    chk("R9 stop drops", stop_req, 0);

    // R7: exhaust with an ACK byte in the same cycle
    cnt_value = 8'd1; cnt_load = 1; tick();
    ack_bit = 0; byte_done = 1; dma_ack = 1;
    tick();
    chk("R7 ack collision", flags3(), 7);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule